// File: doc/BRIEF.md
# Half-Duplex Ethernet Transmit Collision and Deferral Controller

This block supervises the timing of a half-duplex Ethernet transmitter, one frame attempt at a time. It does not serialize bits or compute a CRC. It decides when the serializer may send, when a jam must replace the data, and whether a collided frame is retried or abandoned. All of its time bases advance on a bit-time tick input, so the system clock can run at any rate above the bit rate.

A request enters on `frame_start`. Before any attempt, the first one included, the controller defers until the medium has been quiet for the interframe gap. Carrier that returns early in the gap restarts the wait, and carrier that returns late is disregarded. The serializer then reports each sent bit on `tx_bit_vld`, and dropping it ends the frame. A collision forces a jam of ones, which is held back until any preamble in progress has finished. An early collision leads to a random backoff, counted in slot times and drawn by truncated binary exponential selection from an LFSR, and then to a retransmission. A late collision, or too many attempts, closes the frame with an error code.

Top module: `ethtx_defer_ctrl`

## Requirements
- R1: After `frame_start` in idle, and again after each backoff, `tx_allowed` rises only once IFG_BITS (96) ticks have elapsed with `carrier_sense` low.
- R2: If `carrier_sense` is high on a tick while fewer than HOLD_BITS (64) gap ticks have been counted, the gap count restarts from zero. Carrier seen after that point is ignored and the gap completes on schedule.
- R3: A collision sampled on a tick outside the preamble drives `jam_en` high for exactly JAM_BITS (32) ticks, and `tx_allowed` is low while `jam_en` is high.
- R4: A collision sampled while `in_preamble` is high keeps `tx_allowed` high and `jam_en` low until `in_preamble` is low on a tick. The jam of R3 starts from that tick.
- R5: A collision taken when fewer than COLL_WIN_BITS (512) bits have been sent is followed by a backoff of r×SLOT_BITS ticks, with r in [0, 2^k−1] and k = min(collision count, BACKOFF_CAP). The interframe gap of R1 follows. `retry_start` pulses for one cycle in the same cycle that `tx_allowed` rises for the retransmission, and it never pulses on a first attempt.
- R6: A collision taken after COLL_WIN_BITS or more bits is not retried. One cycle after the jam ends, `stat_vld` pulses with `stat_code` = 2 (late collision), and the block returns to idle.
- R7: The MAX_ATTEMPTS-th (16th) collision of a frame ends it after its jam, with `stat_vld` and `stat_code` = 3 (retry limit) and no further attempt.
- R8: In the transmit state, a tick with `tx_bit_vld` low after at least one sent bit ends the frame. `stat_vld` pulses for one cycle with `stat_code` = 1 (ok), and `tx_allowed` falls. When `stat_vld` is low, `stat_code` is 0.
- R9: Gap, backoff, jam and bit counters advance only on cycles with `bit_tick` high.
- R10: `frame_start` is ignored unless the block is idle.
- R11: After reset, `jam_en`, `tx_allowed`, `retry_start` and `stat_vld` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| frame_start | input | 1 | Request to transmit a new frame |
| tx_bit_vld | input | 1 | Serializer sent a bit on this tick; low ends the frame |
| coll_det | input | 1 | Collision detected on the medium |
| carrier_sense | input | 1 | Medium busy |
| in_preamble | input | 1 | Serializer is still sending preamble |
| jam_en | output | 1 | Send jam ones instead of data |
| tx_allowed | output | 1 | Serializer may send preamble and data |
| retry_start | output | 1 | One-cycle pulse as a retransmission begins |
| stat_vld | output | 1 | One-cycle pulse with a final frame status |
| stat_code | output | 2 | 1 ok, 2 late collision, 3 retry limit, 0 otherwise |

## Verification
The bench builds the block with SLOT_BITS at 16 and BACKOFF_CAP at 4, and keeps the default jam length, gap, hold window, collision window and attempt limit. With these values the worst-case backoff is 240 ticks, so a frame can run through all sixteen collisions to the retry-limit status in a few thousand cycles. Each measured backoff can be tested for slot alignment and range against its truncated exponent. The default 512-bit collision window stays in place, so the bench can place collisions at 511 and 512 bits sent and see both sides of the retry/late decision.

// File: rtl/ethtx_defer_pkg.sv
package ethtx_defer_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEFER,
    S_TX,
    S_PREWAIT,
    S_JAM,
    S_BACKOFF
  } tx_state_e;

  typedef enum logic [1:0] {
    ST_NONE  = 2'd0,
    ST_OK    = 2'd1,
    ST_LATE  = 2'd2,
    ST_LIMIT = 2'd3
  } tx_status_e;

  // Largest backoff draw, in slots, after coll_n collisions: 2^min(n,cap) - 1
  function automatic int unsigned backoff_span(int unsigned coll_n, int unsigned cap);
    int unsigned k;
    k = (coll_n < cap) ? coll_n : cap;
    return (32'd1 << k) - 32'd1;
  endfunction

endpackage

// File: rtl/ethtx_lfsr.sv
module ethtx_lfsr #(
  parameter int unsigned W     = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'h1D0F,
  parameter int unsigned OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] state;

  // Galois form, free running so the draw depends on when the collision lands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= SEED;
    else if (state[0]) state <= (state >> 1) ^ TAPS;
    else               state <= state >> 1;
  end

  assign rnd = state[OUT_W-1:0];

  a_r5_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n) state != '0);

endmodule

// File: rtl/ethtx_gap_timer.sv
module ethtx_gap_timer #(
  parameter int unsigned IFG_BITS  = 96,
  parameter int unsigned HOLD_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic active,
  input  logic carrier,
  output logic done,
  output logic restart
);
  localparam int unsigned CW = $clog2(IFG_BITS);
  localparam logic [CW-1:0] LAST = CW'(IFG_BITS - 1);
  localparam logic [CW-1:0] HOLD = CW'(HOLD_BITS);

  logic [CW-1:0] gap_cnt;

  // Carrier inside the hold window throws the count away; after it, carrier is ignored
  assign restart = active & tick & carrier & (gap_cnt < HOLD);
  assign done    = active & tick & ~restart & (gap_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_cnt <= '0;
    else if (!active)          gap_cnt <= '0;
    else if (tick) begin
      if (restart || done)     gap_cnt <= '0;
      else                     gap_cnt <= gap_cnt + 1'b1;
    end
  end

  a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (gap_cnt == '0));
  a_r9_gap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(gap_cnt));

endmodule

// File: rtl/ethtx_slot_timer.sv
module ethtx_slot_timer #(
  parameter int unsigned SLOT_BITS = 512,
  parameter int unsigned SW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [SW-1:0] slots,
  output logic          busy,
  output logic          done
);
  localparam int unsigned BW = $clog2(SLOT_BITS);
  localparam logic [BW-1:0] LAST = BW'(SLOT_BITS - 1);

  logic [SW-1:0] slots_left;
  logic [BW-1:0] slot_bit;

  assign busy = (slots_left != '0);
  assign done = busy & tick & (slots_left == SW'(1)) & (slot_bit == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_left <= '0;
      slot_bit   <= '0;
    end else if (load) begin
      slots_left <= slots;
      slot_bit   <= '0;
    end else if (busy && tick) begin
      if (slot_bit == LAST) begin
        slot_bit   <= '0;
        slots_left <= slots_left - 1'b1;
      end else begin
        slot_bit   <= slot_bit + 1'b1;
      end
    end
  end

  a_r5_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  a_r9_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !load) |=> ($stable(slots_left) && $stable(slot_bit)));

endmodule

// File: rtl/ethtx_defer_ctrl.sv
module ethtx_defer_ctrl
  import ethtx_defer_pkg::*;
#(
  parameter int unsigned JAM_BITS      = 32,
  parameter int unsigned SLOT_BITS     = 512,
  parameter int unsigned COLL_WIN_BITS = 512,
  parameter int unsigned IFG_BITS      = 96,
  parameter int unsigned HOLD_BITS     = 64,
  parameter int unsigned MAX_ATTEMPTS  = 16,
  parameter int unsigned BACKOFF_CAP   = 10,
  parameter int unsigned LFSR_W        = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'h1D0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       frame_start,
  input  logic       tx_bit_vld,
  input  logic       coll_det,
  input  logic       carrier_sense,
  input  logic       in_preamble,
  output logic       jam_en,
  output logic       tx_allowed,
  output logic       retry_start,
  output logic       stat_vld,
  output logic [1:0] stat_code
);
  localparam int unsigned BW = $clog2(COLL_WIN_BITS + 1);
  localparam int unsigned JW = $clog2(JAM_BITS);
  localparam int unsigned AW = $clog2(MAX_ATTEMPTS + 1);
  localparam int unsigned SW = BACKOFF_CAP;
  localparam logic [BW-1:0] WIN      = BW'(COLL_WIN_BITS);
  localparam logic [JW-1:0] JAM_LAST = JW'(JAM_BITS - 1);
  localparam logic [AW-1:0] MAX_N    = AW'(MAX_ATTEMPTS);

  tx_state_e      st, st_nx;
  logic [BW-1:0]  bits_sent;
  logic [JW-1:0]  jam_cnt;
  logic [AW-1:0]  coll_n, coll_n_nx;
  logic           late_q;
  logic [SW-1:0]  rnd, bo_slots;
  logic           gap_done, gap_restart;
  logic           bo_busy, bo_done, bo_load;

  // Named internal events
  logic ev_coll, ev_jam_end, ev_frame_ok, ev_late, ev_limit, ev_pre_over;

  assign ev_coll     = (st == S_TX) & bit_tick & coll_det;
  assign ev_frame_ok = (st == S_TX) & bit_tick & ~coll_det & ~tx_bit_vld & (bits_sent != '0);
  assign ev_pre_over = (st == S_PREWAIT) & bit_tick & ~in_preamble;
  assign ev_jam_end  = (st == S_JAM) & bit_tick & (jam_cnt == JAM_LAST);
  assign coll_n_nx   = coll_n + 1'b1;
  assign ev_late     = ev_jam_end & late_q;
  assign ev_limit    = ev_jam_end & ~late_q & (coll_n_nx == MAX_N);
  assign bo_slots    = rnd & SW'(backoff_span(32'(coll_n_nx), BACKOFF_CAP));
  assign bo_load     = ev_jam_end & ~late_q & ~ev_limit & (bo_slots != '0);

  ethtx_lfsr #(
    .W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .OUT_W(SW)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  ethtx_gap_timer #(
    .IFG_BITS(IFG_BITS), .HOLD_BITS(HOLD_BITS)
  ) u_gap (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .active(st == S_DEFER),
    .carrier(carrier_sense), .done(gap_done), .restart(gap_restart)
  );

  ethtx_slot_timer #(
    .SLOT_BITS(SLOT_BITS), .SW(SW)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .load(bo_load),
    .slots(bo_slots), .busy(bo_busy), .done(bo_done)
  );

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:    if (frame_start) st_nx = S_DEFER;
      S_DEFER:   if (gap_done) st_nx = S_TX;
      S_TX: begin
        if (ev_coll)          st_nx = in_preamble ? S_PREWAIT : S_JAM;
        else if (ev_frame_ok) st_nx = S_IDLE;
      end
      S_PREWAIT: if (ev_pre_over) st_nx = S_JAM;
      S_JAM: begin
        if (ev_jam_end) begin
          if (ev_late || ev_limit)  st_nx = S_IDLE;
          else if (bo_slots == '0)  st_nx = S_DEFER;
          else                      st_nx = S_BACKOFF;
        end
      end
      S_BACKOFF: if (bo_done) st_nx = S_DEFER;
      default:   st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      bits_sent   <= '0;
      jam_cnt     <= '0;
      coll_n      <= '0;
      late_q      <= 1'b0;
      retry_start <= 1'b0;
      stat_vld    <= 1'b0;
      stat_code   <= ST_NONE;
    end else begin
      st <= st_nx;
      if (st == S_DEFER) bits_sent <= '0;
      else if ((st == S_TX) && bit_tick && !coll_det && tx_bit_vld && (bits_sent != WIN))
        bits_sent <= bits_sent + 1'b1;
      if (st != S_JAM)   jam_cnt <= '0;
      else if (bit_tick) jam_cnt <= jam_cnt + 1'b1;
      if ((st == S_IDLE) && frame_start) coll_n <= '0;
      else if (ev_jam_end && !late_q)    coll_n <= coll_n_nx;
      if (ev_coll) late_q <= (bits_sent == WIN);
      retry_start <= (st == S_DEFER) & gap_done & (coll_n != '0);
      stat_vld    <= ev_frame_ok | ev_late | ev_limit;
      if (ev_frame_ok)   stat_code <= ST_OK;
      else if (ev_late)  stat_code <= ST_LATE;
      else if (ev_limit) stat_code <= ST_LIMIT;
      else               stat_code <= ST_NONE;
    end
  end

  assign jam_en     = (st == S_JAM);
  assign tx_allowed = (st == S_TX) | (st == S_PREWAIT);

  a_r1_tx_after_defer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_allowed) |-> $past(st == S_DEFER));
  a_r3_jam_excl: assert property (@(posedge clk) disable iff (!rst_n)
    jam_en |-> !tx_allowed);
  a_r4_jam_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_en) |-> $past(!in_preamble));
  a_r5_retry_with_tx: assert property (@(posedge clk) disable iff (!rst_n)
    retry_start |-> tx_allowed);
  a_r6_late_after_jam: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_vld && stat_code == ST_LATE) |-> $past(jam_en));
  a_r7_attempt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    coll_n <= MAX_N);
  a_r8_stat_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld |=> !stat_vld);
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_TX) && frame_start && !ev_coll && !ev_frame_ok) |=> (st == S_TX));

endmodule

// File: tb/sim_ethtx_defer_ctrl.sv
`timescale 1ns/1ps
module sim_ethtx_defer_ctrl;
  localparam int SLOT = 16;
  localparam int CAP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b1, frame_start = 1'b0, tx_bit_vld = 1'b0;
  logic coll_det = 1'b0, carrier_sense = 1'b0, in_preamble = 1'b0;
  logic jam_en, tx_allowed, retry_start, stat_vld;
  logic [1:0] stat_code;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ethtx_defer_ctrl #(.SLOT_BITS(SLOT), .BACKOFF_CAP(CAP)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
    .tx_bit_vld(tx_bit_vld), .coll_det(coll_det), .carrier_sense(carrier_sense),
    .in_preamble(in_preamble), .jam_en(jam_en), .tx_allowed(tx_allowed),
    .retry_start(retry_start), .stat_vld(stat_vld), .stat_code(stat_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int span(input int n);
    return (1 << ((n < CAP) ? n : CAP)) - 1;
  endfunction

  task automatic start_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic wait_allowed(output int n);
    n = 0;
    while (!tx_allowed && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic send_ok(input int nbits, input string req);
    tx_bit_vld = 1'b1;
    repeat (nbits) @(negedge clk);
    tx_bit_vld = 1'b0;
    @(negedge clk);
    chk(stat_vld && stat_code == 2'd1, req, {stat_vld, stat_code}, 5);
    chk(!tx_allowed, req, tx_allowed, 0);
    @(negedge clk);
    chk(!stat_vld && stat_code == 2'd0, req, {stat_vld, stat_code}, 0);
  endtask

  task automatic collide(input int nbits, input bit pre);
    tx_bit_vld = 1'b1;
    in_preamble = pre;
    repeat (nbits) @(negedge clk);
    coll_det = 1'b1;
    @(negedge clk);
    coll_det = 1'b0;
    tx_bit_vld = 1'b0;
  endtask

  task automatic count_jam(input string req);
    int n = 0;
    int bad = 0;
    while (jam_en && n < 1000) begin
      if (tx_allowed) bad++;
      n++;
      @(negedge clk);
    end
    chk(n == 32, req, n, 32);
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic check_backoff(input int m, input int coll_n, input string req);
    int r;
    r = (m - 96) / SLOT;
    chk(m >= 96 && ((m - 96) % SLOT) == 0, req, m, 96);
    chk(r <= span(coll_n), req, r, span(coll_n));
    chk(retry_start == 1'b1, req, retry_start, 1);
  endtask

  task automatic t_reset();
    chk(!jam_en && !tx_allowed && !retry_start && !stat_vld, "R11",
        {jam_en, tx_allowed, retry_start, stat_vld}, 0);
  endtask

  task automatic t_ok_frame();
    int m;
    start_frame();
    wait_allowed(m);
    chk(m == 96, "R1", m, 96);
    chk(!retry_start, "R5 first attempt", retry_start, 0);
    send_ok(100, "R8");
  endtask

  task automatic t_carrier_restart();
    int m;
    carrier_sense = 1'b1;
    start_frame();
    repeat (50) @(negedge clk);
    chk(!tx_allowed, "R2 busy", tx_allowed, 0);
    carrier_sense = 1'b0;
    repeat (30) @(negedge clk);
    carrier_sense = 1'b1;
    repeat (5) @(negedge clk);
    carrier_sense = 1'b0;
    wait_allowed(m);
    chk(m == 96, "R2 restart", m, 96);
    send_ok(8, "R8");
  endtask

  task automatic t_carrier_commit();
    int m;
    start_frame();
    repeat (70) @(negedge clk);
    carrier_sense = 1'b1;
    repeat (10) @(negedge clk);
    carrier_sense = 1'b0;
    wait_allowed(m);
    chk(70 + 10 + m == 96, "R2 commit", 80 + m, 96);
    send_ok(8, "R8");
  endtask

  task automatic t_tick_gating();
    int ticks = 0;
    int cyc = 0;
    bit_tick = 1'b0;
    start_frame();
    while (!tx_allowed && cyc < 2000) begin
      bit_tick = (cyc % 3 == 0);
      @(negedge clk);
      if (bit_tick) ticks++;
      cyc++;
    end
    bit_tick = 1'b1;
    chk(ticks == 96, "R9", ticks, 96);
    chk(cyc > 250, "R9 cycles", cyc, 286);
    send_ok(8, "R8");
  endtask

  task automatic t_start_ignored();
    int m;
    int extra = 0;
    start_frame();
    wait_allowed(m);
    tx_bit_vld = 1'b1;
    repeat (5) @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    chk(tx_allowed, "R10 still tx", tx_allowed, 1);
    send_ok(5, "R10");
    repeat (150) begin
      @(negedge clk);
      if (tx_allowed || stat_vld) extra++;
    end
    chk(extra == 0, "R10 idle", extra, 0);
  endtask

  task automatic t_early_coll();
    int m;
    start_frame();
    wait_allowed(m);
    collide(511, 1'b0);
    count_jam("R3");
    chk(!stat_vld, "R5 no status", stat_vld, 0);
    wait_allowed(m);
    check_backoff(m, 1, "R5");
    @(negedge clk);
    chk(!retry_start, "R5 pulse", retry_start, 0);
    send_ok(20, "R8");
  endtask

  task automatic t_late_coll();
    int m;
    int extra = 0;
    start_frame();
    wait_allowed(m);
    collide(512, 1'b0);
    count_jam("R3");
    chk(stat_vld && stat_code == 2'd2, "R6", {stat_vld, stat_code}, 6);
    repeat (150) begin
      @(negedge clk);
      if (tx_allowed || retry_start || stat_vld) extra++;
    end
    chk(extra == 0, "R6 no retry", extra, 0);
  endtask

  task automatic t_preamble();
    int m;
    int bad = 0;
    start_frame();
    wait_allowed(m);
    collide(10, 1'b1);
    repeat (20) begin
      if (jam_en || !tx_allowed) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R4 hold", bad, 0);
    in_preamble = 1'b0;
    @(negedge clk);
    chk(jam_en, "R4 jam", jam_en, 1);
    count_jam("R4");
    wait_allowed(m);
    check_backoff(m, 1, "R4 retry");
    send_ok(8, "R8");
  endtask

  task automatic t_retry_limit();
    int m;
    start_frame();
    for (int i = 1; i <= 16; i++) begin
      wait_allowed(m);
      if (i == 1) chk(m == 96 && !retry_start, "R1", m, 96);
      else        check_backoff(m, i - 1, "R5 multi");
      collide(5, 1'b0);
      count_jam("R3");
      if (i < 16) chk(!stat_vld, "R7 early", stat_vld, 0);
      else        chk(stat_vld && stat_code == 2'd3, "R7", {stat_vld, stat_code}, 7);
    end
    repeat (300) @(negedge clk);
    chk(!tx_allowed, "R7 abandoned", tx_allowed, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ok_frame();
    t_carrier_restart();
    t_carrier_commit();
    t_tick_gating();
    t_start_ignored();
    t_early_coll();
    t_late_coll();
    t_preamble();
    t_retry_limit();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #760000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule